// File: doc/BRIEF.md
# Six-Bit Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a six-bit successive-approximation converter. A start pulse launches a conversion. The sequencer then drives a trial code to an external resistor-ladder DAC and reads back one comparator bit. It decides one result bit per step, most significant bit first, and ends by publishing the six-bit result together with a single-cycle done pulse.

The pace comes from an internal slot timer. Every bit step lasts exactly `SLOT_CYCLES` reference cycles, and the comparator is sampled on the last cycle of each step. With a 4.5 MHz reference and the default of 960 cycles per step, a full conversion takes 5760 cycles, which is 1.28 ms. Full scale, code 63, stands for 63/96 of the supply, so one code step is supply/96. The external DAC is expected to place each trial level half a step below the nominal code, which holds the quantisation error within ±1/2 step. Only the code itself comes from this block. A busy flag covers the conversion, and a synchronous reset aborts it cleanly.

Top module: `sar6_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trial_o`, `result_o`, `busy_o` and `done_o` all become zero.
- R2: A high `start_i` sampled while `busy_o` is low starts a conversion. After that edge `busy_o` is 1 and `trial_o` is 6'b100000 (only bit 5 set).
- R3: A high `start_i` sampled while `busy_o` is high is ignored. The trial sequence, the conversion length and the result are the same as without it.
- R4: The trial code changes only at step boundaries. Each step lasts `SLOT_CYCLES` clock cycles, so `done_o` rises exactly `6*SLOT_CYCLES` cycles after the edge that accepted the start.
- R5: At the end of each step the bit under test is kept if `comp_below_i` is 0 and cleared if it is 1 (1 means the input is below the DAC level). In the same edge the next lower bit is set in `trial_o`.
- R6: When the comparator reports `input < trial_o` for a stored input code, the result equals that input code for every value from 0 to 63.
- R7: `done_o` is high for exactly one cycle, in the cycle in which `result_o` shows the new value. In that same cycle `busy_o` is 0 and `trial_o` is back at 0.
- R8: `result_o` holds its value between conversions and is unaffected by `comp_below_i` while idle.
- R9: A reset during a conversion aborts it. No `done_o` follows, and the block stays idle until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled on each rising edge |
| comp_below_i | input | 1 | Comparator: 1 when the analog input is below the DAC level |
| trial_o | output | 6 | Trial code to the DAC |
| busy_o | output | 1 | High while a conversion runs |
| result_o | output | 6 | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when `result_o` updates |

## Verification
The bench targets the extreme codes 0 and 63 and the codes on either side of the half-scale boundary, 31 and 32. A design that inverts the keep/clear decision, or that shifts the pointer before deciding, returns the wrong code at these values. It follows the trial code at every cycle of each step, so a design that sets the next bit late or samples the comparator a cycle early shows a mismatch at a step edge. A second start is sent in the middle of a conversion; a design that restarts on it finishes late or with a different code. A reset is applied mid-conversion, and a design that keeps running after the abort would raise a stray done pulse.

// File: rtl/sar6_pkg.sv
// Shared definitions for the six-bit successive-approximation sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package sar6_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_t;

    // Index of the bit tested first in a conversion.
    function automatic int unsigned top_bit(input int unsigned width);
        return width - 1;
    endfunction

endpackage

// File: rtl/sar6_slot_timer.sv
// Step timer: counts reference cycles while a conversion runs and flags
// the last cycle of each bit step. Assumes SLOT_CYCLES >= 2. The counter
// stays at zero while idle, so every conversion starts on a fresh step.
module sar6_slot_timer #(
    parameter int unsigned SLOT_CYCLES = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic slot_end_o
);
    localparam int unsigned CW = $clog2(SLOT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter within the current step; wraps at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Last cycle of a step while running.
    assign slot_end_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/sar6_step_reg.sv
// Trial-code register and one-hot bit pointer of the successive
// approximation. Load seeds the MSB; each step decides the bit under the
// pointer from the comparator and seeds the next lower bit. After the LSB
// step both registers return to zero. Assumes load and step never coincide.
module sar6_step_reg #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             below_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] decided_o,
    output logic             last_o
);
    logic [WIDTH-1:0] trial_q;
    logic [WIDTH-1:0] ptr_q;
    logic [WIDTH-1:0] next_trial;

    // Per-bit decision: clear the bit under test when the input is below.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign decided_o[b] = trial_q[b] & ~(ptr_q[b] & below_i);
        if (b == WIDTH - 1) begin : g_top
            assign next_trial[b] = decided_o[b];
        end else begin : g_low
            assign next_trial[b] = decided_o[b] | ptr_q[b+1];
        end
    end

    // Register update on load, step and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= '0;
            ptr_q   <= '0;
        end else if (load_i) begin
            trial_q <= WIDTH'(1) << (WIDTH - 1);
            ptr_q   <= WIDTH'(1) << (WIDTH - 1);
        end else if (step_i) begin
            ptr_q   <= ptr_q >> 1;
            trial_q <= ptr_q[0] ? '0 : next_trial;
        end
    end

    assign trial_o = trial_q;
    assign last_o  = ptr_q[0];

endmodule

// File: rtl/sar6_sequencer.sv
// Top of the six-bit successive-approximation sequencer. Accepts a start
// while idle, runs WIDTH steps of SLOT_CYCLES cycles each, then publishes
// the result with a one-cycle done pulse. Starts seen while busy are
// dropped. Assumes comp_below_i is settled by the last cycle of each step.
module sar6_sequencer #(
    parameter int unsigned WIDTH       = 6,
    parameter int unsigned SLOT_CYCLES = 960
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_below_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);
    import sar6_pkg::*;

    sar_state_t       state_q;
    logic             accept;
    logic             slot_end;
    logic             last_bit;
    logic             finish;
    logic [WIDTH-1:0] decided;

    assign busy_o = (state_q == ST_CONV);
    assign accept = start_i && (state_q == ST_IDLE);
    assign finish = slot_end && last_bit;

    sar6_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy_o),
        .slot_end_o(slot_end)
    );

    sar6_step_reg #(.WIDTH(WIDTH)) step_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (slot_end),
        .below_i  (comp_below_i),
        .trial_o  (trial_o),
        .decided_o(decided),
        .last_o   (last_bit)
    );

    // Idle/converting state: enter on accepted start, leave after LSB step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_CONV;
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

    // Result register and done pulse, both updated by the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                result_o <= decided;
            end
        end
    end

endmodule

// File: rtl/sar6_sequencer_chk.sv
// Protocol checker for sar6_sequencer, attached by bind below. Watches
// only ports; counts busy cycles with its own counter to judge timing.
module sar6_sequencer_chk #(
    parameter int unsigned WIDTH       = 6,
    parameter int unsigned SLOT_CYCLES = 960
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] trial_o,
    input logic             busy_o,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o
);
    logic [31:0] busy_cnt;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) busy_cnt <= '0;
        else                   busy_cnt <= busy_cnt + 1;
    end

    assert_start_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && trial_o == (WIDTH'(1) << (WIDTH - 1))));

    assert_busy_start_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o));

    assert_conv_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o) && busy_cnt == 0) |-> 1'b1 ##0
        (done_o == 1'b0));

    assert_done_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_cnt == 32'(WIDTH * SLOT_CYCLES - 1)) |=> done_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && trial_o == '0));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o)));

endmodule

bind sar6_sequencer sar6_sequencer_chk #(
    .WIDTH(WIDTH),
    .SLOT_CYCLES(SLOT_CYCLES)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .trial_o (trial_o),
    .busy_o  (busy_o),
    .result_o(result_o),
    .done_o  (done_o)
);

// File: tb/sar6_sequencer_tb.sv
module sar6_sequencer_tb_top;
    localparam int W = 6;
    localparam int S = 12;
    localparam int NVEC = 8;
    // Each entry: {stimulus input code, expected result}.
    localparam logic [11:0] VEC [NVEC] = '{
        {6'd0, 6'd0}, {6'd63, 6'd63}, {6'd32, 6'd32}, {6'd31, 6'd31},
        {6'd1, 6'd1}, {6'd62, 6'd62}, {6'd42, 6'd42}, {6'd21, 6'd21}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] vin = '0;
    logic [W-1:0] trial, result;
    logic         busy, done, below;
    int           total = 0;
    int           bad = 0;

    always #5 clk = ~clk;

    // Behavioural DAC plus comparator.
    assign below = (vin < trial);

    sar6_sequencer #(.WIDTH(W), .SLOT_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .comp_below_i(below),
        .trial_o(trial), .busy_o(busy), .result_o(result), .done_o(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected trial code during step k of a conversion of code c.
    function automatic int exp_trial(input int c, input int k);
        int upper_mask;
        upper_mask = ((1 << W) - 1) & ~((1 << (W - k)) - 1);
        return (c & upper_mask) | (1 << (W - 1 - k));
    endfunction

    // Runs one conversion; optionally pulses start again at cycle 'again'.
    task automatic convert(input int code, input int expv, input int again);
        int n;
        bit seq_ok;
        int bad_act, bad_exp;
        vin = W'(code);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1 && trial == 6'b100000, "R2 start seed", trial, 32);
        n = 0;
        seq_ok = 1'b1;
        bad_act = 0;
        bad_exp = 0;
        while (!done && n < 10 * S * W) begin
            if (seq_ok && trial != W'(exp_trial(code, n / S))) begin
                seq_ok = 1'b0;
                bad_act = trial;
                bad_exp = exp_trial(code, n / S);
            end
            if (n == again) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check(seq_ok, "R5 trial sequence", bad_act, bad_exp);
        check(n == W * S, again >= 0 ? "R3 length with extra start" : "R4 length", n, W * S);
        check(result == W'(expv), again >= 0 ? "R3 result with extra start" : "R6 result", result, expv);
        check(!busy && trial == '0, "R7 idle at done", trial, 0);
        @(negedge clk);
        check(!done, "R7 done single cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(trial == '0 && result == '0 && !busy && !done, "R1 reset state", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            convert(VEC[i][11:6], VEC[i][5:0], -1);
        end

        // R8: result held while idle and the comparator moves.
        vin = 6'd0;
        repeat (20) @(negedge clk);
        check(result == 6'd21 && !done, "R8 result hold", result, 21);

        // R3: extra start in mid-conversion.
        convert(45, 45, 2 * S + 3);

        // R9: reset during a conversion.
        vin = 6'd50;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (2 * S + 5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && trial == '0 && result == '0 && !done, "R9 abort state", trial, 0);
        rst_n = 1'b1;
        begin
            bit saw_done;
            saw_done = 1'b0;
            for (int c = 0; c < W * S + 10; c++) begin
                @(negedge clk);
                if (done || busy) saw_done = 1'b1;
            end
            check(!saw_done, "R9 no done after abort", saw_done, 0);
        end

        // Full-code sweep for R6.
        begin
            int errs;
            errs = 0;
            for (int c = 0; c < 64; c++) begin
                vin = W'(c);
                @(negedge clk) start = 1'b1;
                @(negedge clk) start = 1'b0;
                while (!done) @(negedge clk);
                if (result != W'(c)) errs++;
            end
            check(errs == 0, "R6 full sweep", errs, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R4 watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule